// File: doc/BRIEF.md
# Slot-Table Time-Division Memory Arbiter

This block shares each of two memory regions, one external and one internal, among fourteen clients in time slices. Each region steps through a 64-entry slot table. Every entry names the client that owns that slot. A client placed in more slots receives a larger share of the bandwidth. Software fills each table one entry at a time: it selects a region and a slot index and writes a client number. Each region has its own table, its own slot pointer and its own grant logic, so the two never interact.

Within a slot, the owner is granted if it requests. If it does not, the slot goes to the next requesting client in circular order after the owner. If nobody requests, no grant is given. Entry values 14 and 15 mark an idle slot. An idle slot goes to the lowest-numbered requesting client. The grant is a combinational function of the request lines and a registered owner. The owner register is reloaded at each slot boundary, which is marked by the region's advance strobe.

Top module: `tdm_mem_arbiter`

## Requirements
- R1: After reset every table entry holds client 0 and both slot pointers are at slot 0, so with all clients requesting, client 0 is granted in every slot.
- R2: When the current slot's owner (entry value 0..13) requests, the owner is granted.
- R3: When the owner (0..13) does not request, the grant goes to the first requesting client found in the order owner+1, owner+2, … modulo 14.
- R4: With no request in a region, that region's grant vector is all zero and its valid output is low.
- R5: An entry holding 14 or 15 is idle: the lowest-numbered requesting client is granted.
- R6: A region's slot pointer moves one slot per advance strobe, holds without one, and wraps from 63 to 0.
- R7: A table write changes grants only from the next slot boundary on. A write to the slot being entered on the same clock as an advance is used for that slot.
- R8: The two regions are independent: writes aimed at one region and strobes of one region leave the other's grants unchanged.
- R9: Each grant vector is zero or one-hot. When valid, its set bit index equals the granted id output.
- R10: With all clients requesting, a client that owns k of the 64 entries is granted in exactly k slots of a full pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 14 | External-region request lines, bit i = client i |
| int_req | input | 14 | Internal-region request lines |
| ext_adv | input | 1 | External-region slot boundary strobe |
| int_adv | input | 1 | Internal-region slot boundary strobe |
| tbl_we | input | 1 | Table entry write enable |
| tbl_region | input | 1 | Target table: 0 external, 1 internal |
| tbl_slot | input | 6 | Slot index of the entry written |
| tbl_client | input | 4 | Client id written (14/15 = idle) |
| ext_gnt | output | 14 | External one-hot grant |
| ext_gnt_vld | output | 1 | External grant present |
| ext_gnt_id | output | 4 | External granted client id |
| int_gnt | output | 14 | Internal one-hot grant |
| int_gnt_vld | output | 1 | Internal grant present |
| int_gnt_id | output | 4 | Internal granted client id |

## Verification
A request change appears on the grant outputs in the same cycle, because the selection is combinational from the registered owner. An advance strobe or a table write is seen one rising edge later, when the owner register reloads. The bench drives inputs just after the falling edge and compares the outputs with its model one time unit later. Only after the following rising edge does it apply the strobe and write to the model's pointer, owner and table. Every output is therefore checked against the state that the last edge should have produced.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    localparam int N_CLIENTS = 14;
    localparam int N_SLOTS   = 64;
    localparam int N_REGIONS = 2;
    localparam int ID_W      = 4;
    localparam int SLOT_W    = $clog2(N_SLOTS);

    typedef logic [ID_W-1:0]      client_id_t;
    typedef logic [SLOT_W-1:0]    slot_idx_t;
    typedef logic [N_CLIENTS-1:0] client_vec_t;

    typedef struct packed {
        logic       valid;
        client_id_t id;
    } grant_t;

    typedef struct packed {
        logic       en;
        logic       region;
        slot_idx_t  slot;
        client_id_t id;
    } tbl_wr_t;

    function automatic logic id_is_client(client_id_t id);
        return int'(id) < N_CLIENTS;
    endfunction

    // Owner first, else circular search after owner; idle owner searches from 0.
    function automatic grant_t pick_client(client_id_t owner, client_vec_t req);
        grant_t g;
        int     base;
        g = '0;
        base = id_is_client(owner) ? int'(owner) : N_CLIENTS - 1;
        for (int k = 1; k <= N_CLIENTS; k++) begin
            int c;
            c = (base + k) % N_CLIENTS;
            if (!g.valid && req[c]) begin
                g.valid = 1'b1;
                g.id    = client_id_t'(c);
            end
        end
        if (id_is_client(owner)) begin
            if (req[owner]) begin
                g.valid = 1'b1;
                g.id    = owner;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/slot_table.sv
module slot_table import tdm_arb_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  slot_idx_t  waddr,
    input  client_id_t wdata,
    input  slot_idx_t  raddr,
    output client_id_t rdata
);
    client_id_t mem [N_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SLOTS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/slot_pointer.sv
module slot_pointer import tdm_arb_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    output slot_idx_t ptr,
    output slot_idx_t ptr_next
);
    localparam slot_idx_t LAST = slot_idx_t'(N_SLOTS - 1);

    assign ptr_next = (ptr == LAST) ? '0 : ptr + slot_idx_t'(1);

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= ptr_next;
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr == LAST) |=> ptr == '0); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr)); // R6
endmodule

// File: rtl/grant_decode.sv
module grant_decode import tdm_arb_pkg::*; (
    input  grant_t      g,
    output client_vec_t onehot
);
    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_bit
        assign onehot[i] = g.valid && (g.id == client_id_t'(i));
    end
endmodule

// File: rtl/tdm_region.sv
module tdm_region import tdm_arb_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  client_vec_t req,
    input  logic        adv,
    input  logic        we,
    input  slot_idx_t   waddr,
    input  client_id_t  wdata,
    output client_vec_t gnt,
    output grant_t      grant
);
    slot_idx_t  ptr, ptr_next;
    client_id_t entry_next, owner;

    slot_pointer u_ptr (
        .clk(clk), .rst(rst), .adv(adv), .ptr(ptr), .ptr_next(ptr_next)
    );

    slot_table u_tbl (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(ptr_next), .rdata(entry_next)
    );

    // Owner of the current slot, reloaded only at a slot boundary.
    always_ff @(posedge clk) begin
        if (rst)
            owner <= '0;
        else if (adv)
            owner <= (we && waddr == ptr_next) ? wdata : entry_next;
    end

    assign grant = pick_client(owner, req);

    grant_decode u_dec (.g(grant), .onehot(gnt));

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && (grant.valid == (gnt != '0))); // R9
    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> !grant.valid); // R4
    AST_OWNER_WINS: assert property (@(posedge clk) disable iff (rst)
        (id_is_client(owner) && req[owner]) |-> (grant.valid && grant.id == owner)); // R2
    AST_GNT_IS_REQ: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> req[grant.id]); // R3
    AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(owner)); // R7
    AST_ONE_ID: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> gnt[grant.id]); // R9
endmodule

// File: rtl/tdm_mem_arbiter.sv
module tdm_mem_arbiter import tdm_arb_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CLIENTS-1:0] ext_req,
    input  logic [N_CLIENTS-1:0] int_req,
    input  logic                 ext_adv,
    input  logic                 int_adv,
    input  logic                 tbl_we,
    input  logic                 tbl_region,
    input  logic [SLOT_W-1:0]    tbl_slot,
    input  logic [ID_W-1:0]      tbl_client,
    output logic [N_CLIENTS-1:0] ext_gnt,
    output logic                 ext_gnt_vld,
    output logic [ID_W-1:0]      ext_gnt_id,
    output logic [N_CLIENTS-1:0] int_gnt,
    output logic                 int_gnt_vld,
    output logic [ID_W-1:0]      int_gnt_id
);
    tbl_wr_t     wr;
    client_vec_t req_r [N_REGIONS];
    logic        adv_r [N_REGIONS];
    client_vec_t gnt_r [N_REGIONS];
    grant_t      grant_r [N_REGIONS];

    assign wr = '{en: tbl_we, region: tbl_region, slot: tbl_slot, id: tbl_client};

    assign req_r[0] = ext_req;
    assign req_r[1] = int_req;
    assign adv_r[0] = ext_adv;
    assign adv_r[1] = int_adv;

    for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
        tdm_region u_region (
            .clk(clk), .rst(rst),
            .req(req_r[r]), .adv(adv_r[r]),
            .we(wr.en && (wr.region == 1'(r))),
            .waddr(wr.slot), .wdata(wr.id),
            .gnt(gnt_r[r]), .grant(grant_r[r])
        );
    end

    assign ext_gnt     = gnt_r[0];
    assign ext_gnt_vld = grant_r[0].valid;
    assign ext_gnt_id  = grant_r[0].id;
    assign int_gnt     = gnt_r[1];
    assign int_gnt_vld = grant_r[1].valid;
    assign int_gnt_id  = grant_r[1].id;
endmodule

// File: tb/test_tdm_mem_arbiter.sv
module test_tdm_mem_arbiter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ext_req = '0, int_req = '0;
    logic        ext_adv = 1'b0, int_adv = 1'b0;
    logic        tbl_we = 1'b0, tbl_region = 1'b0;
    logic [5:0]  tbl_slot = '0;
    logic [3:0]  tbl_client = '0;
    logic [13:0] ext_gnt, int_gnt;
    logic        ext_gnt_vld, int_gnt_vld;
    logic [3:0]  ext_gnt_id, int_gnt_id;

    tdm_mem_arbiter i_tdm_mem_arbiter (.*);

    always #2 clk = ~clk;   // 250 MHz

    int checks = 0, failures = 0;
    int mtbl [2][64];
    int mptr [2];
    int mown [2];
    string tag = "R1";
    bit finished = 0;
    int hits3;

    function automatic int exp_pick(int own, logic [13:0] r);
        int base;
        if (own < 14 && r[own]) return own;
        base = (own < 14) ? own : 13;
        for (int k = 1; k <= 14; k++) begin
            if (r[(base + k) % 14]) return (base + k) % 14;
        end
        return -1;
    endfunction

    function automatic string classify(int own, logic [13:0] r);
        if (r == 0) return "R4";
        if (own >= 14) return "R5";
        if (r[own]) return "R2";
        return "R3";
    endfunction

    task automatic check_region(int rg, logic [13:0] r, logic [13:0] g, logic v, logic [3:0] id);
        int e;
        logic [13:0] eg;
        string t;
        e  = exp_pick(mown[rg], r);
        eg = (e < 0) ? 14'h0 : (14'h1 << e);
        t  = (tag == "") ? classify(mown[rg], r) : tag;
        checks++;
        if (g !== eg || v !== (e >= 0) || (e >= 0 && id !== 4'(e))) begin
            failures++;
            $display("FAIL %s region%0d gnt=%h vld=%b id=%0d expected gnt=%h id=%0d",
                     t, rg, g, v, id, eg, e);
        end
        checks++;
        if (!$onehot0(g) || (v && g !== (14'h1 << id))) begin
            failures++;
            $display("FAIL R9 region%0d gnt=%h id=%0d expected one-hot matching id", rg, g, id);
        end
    endtask

    task automatic step(input logic [13:0] re, input logic [13:0] ri,
                        input logic ae, input logic ai,
                        input logic w, input logic wr, input int ws, input int wd);
        ext_req = re; int_req = ri; ext_adv = ae; int_adv = ai;
        tbl_we = w; tbl_region = wr; tbl_slot = 6'(ws); tbl_client = 4'(wd);
        #1;
        check_region(0, re, ext_gnt, ext_gnt_vld, ext_gnt_id);
        check_region(1, ri, int_gnt, int_gnt_vld, int_gnt_id);
        if (ext_gnt_vld && ext_gnt_id == 4'd3) hits3++;
        @(posedge clk);
        for (int rg = 0; rg < 2; rg++) begin
            int nxt;
            logic a;
            a = (rg == 0) ? ae : ai;
            nxt = (mptr[rg] + 1) % 64;
            if (a) begin
                mown[rg] = (w && int'(wr) == rg && ws == nxt) ? wd : mtbl[rg][nxt];
                mptr[rg] = nxt;
            end
            if (w && int'(wr) == rg) mtbl[rg][ws] = wd;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int rg = 0; rg < 2; rg++) begin
            mptr[rg] = 0; mown[rg] = 0;
            for (int s = 0; s < 64; s++) mtbl[rg][s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all entries client 0
        tag = "R1";
        for (int i = 0; i < 5; i++) step(14'h3FFF, 14'h3FFF, 1, 1, 0, 0, 0, 0);

        // R2/R3: ext slot 6 owned by 5
        tag = "";
        step(0, 0, 0, 0, 1, 0, 6, 5);
        step(0, 0, 1, 0, 0, 0, 0, 0);                         // enter slot 6
        tag = "R3"; step(14'h0200, 0, 0, 0, 0, 0, 0, 0);      // only 9 -> 9
        tag = "R2"; step(14'h0220, 0, 0, 0, 0, 0, 0, 0);      // 5 and 9 -> 5
        tag = "R3"; step(14'h0014, 0, 0, 0, 0, 0, 0, 0);      // 2,4 -> 2 after wrap
        tag = "R4"; step(14'h0000, 14'h0, 0, 0, 0, 0, 0, 0);

        // R5: idle entry 15 at slot 7
        tag = "R5";
        step(0, 0, 0, 0, 1, 0, 7, 15);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(14'h0810, 0, 0, 0, 0, 0, 0, 0);                  // 4,11 -> 4
        step(0, 0, 0, 0, 1, 0, 8, 14);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        step(14'h2000, 0, 0, 0, 0, 0, 0, 0);                  // 13 only

        // R7: write current slot has no effect until boundary
        tag = "R7";
        step(14'h0810, 0, 0, 0, 1, 0, 8, 6);
        step(14'h0850, 0, 0, 0, 0, 0, 0, 0);                  // still idle -> 4
        step(14'h0850, 0, 1, 0, 1, 0, 9, 11);                 // write entering slot
        step(14'h0850, 0, 0, 0, 0, 0, 0, 0);                  // owner 11

        // R8: writes and strobes on ext leave int unchanged
        tag = "R8";
        for (int i = 0; i < 6; i++) step(14'h3FFF, 14'h3FFF, 1, 0, 1, 0, i, 12);
        step(14'h3FFF, 14'h3FFF, 0, 1, 1, 1, 2, 9);
        step(14'h3FFF, 14'h3FFF, 0, 0, 0, 0, 0, 0);

        // R10: ext slots with index%4==0 owned by 3, rest by 7
        tag = "R10";
        for (int s = 0; s < 64; s++) step(14'h3FFF, 0, 0, 0, 1, 0, s, (s % 4 == 0) ? 3 : 7);
        hits3 = 0;
        for (int i = 0; i < 64; i++) step(14'h3FFF, 0, 1, 0, 0, 0, 0, 0);
        checks++;
        if (hits3 != 16) begin
            failures++;
            $display("FAIL R10 client3 slots=%0d expected 16", hits3);
        end

        // R6: full pass plus wrap on both regions
        tag = "R6";
        for (int i = 0; i < 130; i++) step(14'h0088, 14'h1001, 1, i % 2, 0, 0, 0, 0);

        // mixed traffic
        tag = "";
        for (int i = 0; i < 3000; i++)
            step(14'($urandom), 14'($urandom & $urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), int'($urandom % 64), int'($urandom % 16));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule